// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo serial audio stream as a slave: an external bit clock, a word-select line and a data line. All three are sampled in a faster system clock domain. The block finds the bit clock rising edges. It assembles each channel word and returns complete left/right sample pairs as 24-bit two's-complement values, with a one-cycle strobe.

A static two-bit selector picks the framing. One framing places the first data bit one bit period after the word-select change, with the MSB first. The other three framings are right-aligned: the word ends on the last bit before the word-select change, and the word is 16, 20 or 24 bits long. Right-aligned words shorter than 24 bits are sign-extended. If a right-aligned channel slot is too short to hold the selected word length, that word is discarded and a framing error pulse is raised.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is held, and until the first pair is delivered after it, `left_o` and `right_o` read zero and `valid_o` and `frame_err_o` stay low.
- R2: With `fmt_i = 2'b00`, the bit sampled on the second bit-clock rising edge after a word-select change is the MSB of the new word. The next 23 bits fill the sample from bit 23 downward.
- R3: With `fmt_i = 2'b00`, a word shorter than 24 bits leaves the unfilled low bits at zero. Bits past the 24th in a slot are ignored.
- R4: With `fmt_i = 2'b01`, the 16 bits sampled last before a word-select change form the word, MSB first. The word is sign-extended from bit 15 to 24 bits.
- R5: With `fmt_i = 2'b10`, the last 20 bits before the change form the word, which is sign-extended from bit 19.
- R6: With `fmt_i = 2'b11`, the last 24 bits before the change form the word. In every right-aligned mode, bits earlier in the slot have no effect.
- R7: A word sampled while word select is 0 is the left sample, and a word sampled while it is 1 is the right sample. `valid_o` pulses for exactly one cycle after the right word that follows a good left word. `left_o` and `right_o` change only in that cycle.
- R8: In a right-aligned mode, a slot with fewer bits than the selected length gives a one-cycle `frame_err_o` pulse. No `valid_o` is produced for that frame, and the next well-formed frame is delivered normally.
- R9: The partial word that is in progress when the first word-select change after reset is seen is discarded. It produces neither `valid_o` nor `frame_err_o`.
- R10: `valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Static framing select (00 MSB-delayed, 01/10/11 right-aligned 16/20/24) |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select, changes on bit clock falling edge |
| sd_i | input | 1 | Serial data, sampled on bit clock rising edge |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| frame_err_o | output | 1 | One-cycle pulse when a short right-aligned word is dropped |

## Verification
The bench pads every right-aligned slot with ones ahead of the word. A design that counted bits from the start of the slot, rather than keeping the last N, would return those ones. Negative and positive extremes are used in the 16- and 20-bit modes to catch a wrong sign-extension source bit. In the delayed mode the bench sends a 16-bit word and a 28-bit word, which shows whether the design pads low bits with zero and ignores the surplus bits instead of shifting them in. Short slots and a partial word right after reset show whether the design drops the sample silently, reports it, or wrongly pairs a stale left word with a fresh right one.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   // Framing select encoding; values are decoded by the word assembler.
   typedef enum logic [1:0] {
      FMT_DELAYED = 2'b00,
      FMT_RJ_S    = 2'b01,
      FMT_RJ_M    = 2'b10,
      FMT_RJ_L    = 2'b11
   } fmt_e;

   // Right-aligned word length for a given select, relative to the full width.
   function automatic int unsigned rj_len(input logic [1:0] sel, input int unsigned full_w);
      case (sel)
         2'b01:   return full_w - 8;
         2'b10:   return full_w - 4;
         default: return full_w;
      endcase
   endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic ws_i,
   input  logic sd_i,
   output logic rise_o,
   output logic ws_o,
   output logic sd_o
);

   logic [STAGES-1:0] sck_q;
   logic [STAGES-1:0] ws_q;
   logic [STAGES-1:0] sd_q;
   logic              sck_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_q <= '0;
         ws_q  <= '0;
         sd_q  <= '0;
         sck_d <= 1'b0;
      end else begin
         sck_q <= {sck_q[STAGES-2:0], sck_i};
         ws_q  <= {ws_q[STAGES-2:0], ws_i};
         sd_q  <= {sd_q[STAGES-2:0], sd_i};
         sck_d <= sck_q[STAGES-1];
      end
   end

   assign rise_o = sck_q[STAGES-1] & ~sck_d;
   assign ws_o   = ws_q[STAGES-1];
   assign sd_o   = sd_q[STAGES-1];

endmodule

// File: rtl/aud_rx_word.sv
module aud_rx_word
   import aud_rx_pkg::*;
#(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned SLOT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_i,
   input  logic              rise_i,
   input  logic              ws_i,
   input  logic              sd_i,
   output logic              word_vld_o,
   output logic              short_o,
   output logic              word_ch_o,
   output logic [WORD_W-1:0] word_o
);

   localparam int unsigned CNT_W = $clog2(SLOT_W + 1);
   localparam int unsigned N_RJ  = 3;

   logic              seen_q;
   logic              armed_q;
   logic              ws_prev_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] msb_acc_q;
   logic [WORD_W-1:0] shreg_q;

   logic              boundary;
   logic              delayed_mode;
   logic [WORD_W-1:0] msb_next;
   logic [WORD_W-1:0] rj_word [N_RJ];
   logic [1:0]        rj_sel;
   logic [CNT_W-1:0]  need_len;
   logic              too_short;

   assign boundary     = rise_i && seen_q && (ws_i != ws_prev_q);
   assign delayed_mode = (fmt_i == FMT_DELAYED);

   // MSB-first placement for the delayed framing; excess bits fall off.
   always_comb begin
      msb_next = msb_acc_q;
      for (int b = 0; b < int'(WORD_W); b++) begin
         if (cnt_q == CNT_W'(int'(WORD_W) - 1 - b)) msb_next[b] = sd_i;
      end
   end

   // One sign-extended candidate per right-aligned length.
   for (genvar g = 0; g < int'(N_RJ); g++) begin : g_rj
      localparam int unsigned LEN = WORD_W - 8 + 4 * g;
      if (LEN < WORD_W) begin : g_ext
         assign rj_word[g] = {{(WORD_W - LEN){shreg_q[LEN-1]}}, shreg_q[LEN-1:0]};
      end else begin : g_full
         assign rj_word[g] = shreg_q;
      end
   end

   always_comb begin
      case (fmt_i)
         FMT_RJ_M: rj_sel = 2'd1;
         FMT_RJ_L: rj_sel = 2'd2;
         default:  rj_sel = 2'd0;
      endcase
      need_len  = CNT_W'(rj_len(fmt_i, WORD_W));
      too_short = !delayed_mode && (cnt_q < need_len);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         armed_q    <= 1'b0;
         ws_prev_q  <= 1'b0;
         cnt_q      <= '0;
         msb_acc_q  <= '0;
         shreg_q    <= '0;
         word_vld_o <= 1'b0;
         short_o    <= 1'b0;
         word_ch_o  <= 1'b0;
         word_o     <= '0;
      end else begin
         word_vld_o <= 1'b0;
         short_o    <= 1'b0;
         if (rise_i) begin
            seen_q    <= 1'b1;
            ws_prev_q <= ws_i;
            if (boundary) begin
               armed_q <= 1'b1;
               if (armed_q) begin
                  word_ch_o <= ws_prev_q;
                  if (too_short) begin
                     short_o <= 1'b1;
                  end else begin
                     word_vld_o <= 1'b1;
                     word_o     <= delayed_mode ? msb_next : rj_word[rj_sel];
                  end
               end
               msb_acc_q <= '0;
               if (delayed_mode) begin
                  cnt_q   <= '0;
                  shreg_q <= '0;
               end else begin
                  cnt_q   <= CNT_W'(1);
                  shreg_q <= {{(WORD_W-1){1'b0}}, sd_i};
               end
            end else begin
               msb_acc_q <= msb_next;
               shreg_q   <= {shreg_q[WORD_W-2:0], sd_i};
               if (cnt_q != CNT_W'(SLOT_W)) cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld_i,
   input  logic              short_i,
   input  logic              word_ch_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o,
   output logic              frame_err_o
);

   logic [WORD_W-1:0] pend_l_q;
   logic              have_l_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_l_q    <= '0;
         have_l_q    <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
         if (short_i) begin
            frame_err_o <= 1'b1;
            have_l_q    <= 1'b0;
         end else if (word_vld_i) begin
            if (!word_ch_i) begin
               pend_l_q <= word_i;
               have_l_q <= 1'b1;
            end else begin
               have_l_q <= 1'b0;
               if (have_l_q) begin
                  left_o  <= pend_l_q;
                  right_o <= word_i;
                  valid_o <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned SLOT_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_i,
   input  logic              sck_i,
   input  logic              ws_i,
   input  logic              sd_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o,
   output logic              frame_err_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WORD_W < 9) begin : g_bad_word
      $error("WORD_W must leave room for the shortest right-aligned length");
   end
   if (SLOT_W < WORD_W) begin : g_bad_slot
      $error("SLOT_W must be at least WORD_W");
   end

   logic              rise;
   logic              ws_s;
   logic              sd_s;
   logic              w_vld;
   logic              w_short;
   logic              w_ch;
   logic [WORD_W-1:0] w_data;

   aud_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_i  (sck_i),
      .ws_i   (ws_i),
      .sd_i   (sd_i),
      .rise_o (rise),
      .ws_o   (ws_s),
      .sd_o   (sd_s)
   );

   aud_rx_word #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_word (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt_i      (fmt_i),
      .rise_i     (rise),
      .ws_i       (ws_s),
      .sd_i       (sd_s),
      .word_vld_o (w_vld),
      .short_o    (w_short),
      .word_ch_o  (w_ch),
      .word_o     (w_data)
   );

   aud_rx_pair #(.WORD_W(WORD_W)) u_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_vld_i  (w_vld),
      .short_i     (w_short),
      .word_ch_i   (w_ch),
      .word_i      (w_data),
      .left_o      (left_o),
      .right_o     (right_o),
      .valid_o     (valid_o),
      .frame_err_o (frame_err_o)
   );

endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
   parameter int unsigned WORD_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        fmt_i,
   input logic [WORD_W-1:0] left_o,
   input logic [WORD_W-1:0] right_o,
   input logic              valid_o,
   input logic              frame_err_o,
   input logic              w_vld,
   input logic              w_ch
);

   // R1: first cycle out of reset is quiet
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!valid_o && !frame_err_o && left_o == '0 && right_o == '0));

   // R7: a pair is only presented right after a right-channel word
   a_r7_pair_after_right: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(w_vld && w_ch));

   // R7: samples only move with the strobe
   a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R7: strobe lasts one cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R10: never both
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && frame_err_o));

   // R4: 16-bit words carry a uniform upper part
   a_r4_sext16: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && fmt_i == 2'b01) |->
         (($countones(left_o[WORD_W-1:WORD_W-9]) == 0 || $countones(left_o[WORD_W-1:WORD_W-9]) == 9) &&
          ($countones(right_o[WORD_W-1:WORD_W-9]) == 0 || $countones(right_o[WORD_W-1:WORD_W-9]) == 9)));

   // R5: 20-bit words carry a uniform upper part
   a_r5_sext20: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && fmt_i == 2'b10) |->
         (($countones(left_o[WORD_W-1:WORD_W-5]) == 0 || $countones(left_o[WORD_W-1:WORD_W-5]) == 5) &&
          ($countones(right_o[WORD_W-1:WORD_W-5]) == 0 || $countones(right_o[WORD_W-1:WORD_W-5]) == 5)));

endmodule

bind aud_serial_rx aud_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fmt_i       (fmt_i),
   .left_o      (left_o),
   .right_o     (right_o),
   .valid_o     (valid_o),
   .frame_err_o (frame_err_o),
   .w_vld       (w_vld),
   .w_ch        (w_ch)
);

// File: tb/tb_aud_serial_rx.sv
module tb_aud_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic        sck = 1'b0;
   logic        ws = 1'b1;
   logic        sd = 1'b0;
   logic [23:0] left_o, right_o;
   logic        valid_o, frame_err_o;

   int checks = 0;
   int errors = 0;
   int nval = 0;
   int nerr = 0;
   int cycles = 0;
   logic [23:0] capl = '0, capr = '0;

   always #5 clk = ~clk;

   aud_serial_rx dut (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .sck_i(sck), .ws_i(ws), .sd_i(sd),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
   );

   always @(negedge clk) begin
      if (valid_o) begin
         nval = nval + 1;
         capl = left_o;
         capr = right_o;
      end
      if (frame_err_o) nerr = nerr + 1;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_bit(input logic w, input logic d);
      @(negedge clk);
      sck = 1'b0; ws = w; sd = d;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic bit_of(input logic [1:0] f, input int slot, input int wlen,
                                   input logic [31:0] val, input int i);
      int n;
      if (f == 2'b00) return (i >= 1 && i <= wlen) ? val[wlen - i] : 1'b0;
      n = (f == 2'b01) ? 16 : (f == 2'b10) ? 20 : 24;
      return (i >= slot - n) ? val[slot - 1 - i] : 1'b1;
   endfunction

   function automatic logic [23:0] expect_word(input logic [1:0] f, input logic [23:0] v);
      case (f)
         2'b01:   return {{8{v[15]}}, v[15:0]};
         2'b10:   return {{4{v[19]}}, v[19:0]};
         default: return v;
      endcase
   endfunction

   task automatic send_frame(input logic [1:0] f, input int wlen, input logic [31:0] lv,
                             input logic [31:0] rv, input int lslot);
      for (int i = 1; i < lslot; i++) put_bit(1'b0, bit_of(f, lslot, wlen, lv, i));
      for (int i = 0; i < 32; i++) put_bit(1'b1, bit_of(f, 32, wlen, rv, i));
      put_bit(1'b0, (f == 2'b00) ? 1'b0 : 1'b1);
      repeat (10) @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] f);
      @(negedge clk);
      rst_n = 1'b0; sck = 1'b0; ws = 1'b1; sd = 1'b0; fmt = f;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      nval = 0; nerr = 0;
   endtask

   task automatic prime(input logic [1:0] f);
      put_bit(1'b1, 1'b0);
      put_bit(1'b1, 1'b1);
      put_bit(1'b0, (f == 2'b00) ? 1'b0 : 1'b1);
   endtask

   // {fmt, left, right}; delayed-mode entries carry full 24-bit words
   localparam logic [49:0] VEC [6] = '{
      {2'b00, 24'h5A5A5A, 24'hA5A5A5},
      {2'b01, 24'hC37FFF, 24'h128001},
      {2'b10, 24'hF7FFFF, 24'h080000},
      {2'b11, 24'h800001, 24'h7FFFFE},
      {2'b01, 24'h000000, 24'h00FFFF},
      {2'b00, 24'h800000, 24'h000001}
   };

   initial begin
      // R1: reset state
      @(negedge clk); @(negedge clk);
      chk("R1 left at reset", {24'h0, left_o}, 48'h0);
      chk("R1 right at reset", {24'h0, right_o}, 48'h0);
      chk("R1 strobes at reset", {46'h0, valid_o, frame_err_o}, 48'h0);

      foreach (VEC[k]) begin
         logic [1:0]  f;
         logic [23:0] lv, rv;
         f  = VEC[k][49:48];
         lv = VEC[k][47:24];
         rv = VEC[k][23:0];
         do_reset(f);
         prime(f);
         send_frame(f, 24, {8'h0, lv}, {8'h0, rv}, 32);
         // R2/R4/R5/R6 word extraction, R7 steering
         chk("R7 one pair per frame", 48'(nval), 48'd1);
         chk(f == 2'b00 ? "R2 left word" : (f == 2'b01 ? "R4 left word" : (f == 2'b10 ? "R5 left word" : "R6 left word")),
             {24'h0, capl}, {24'h0, expect_word(f, lv)});
         chk(f == 2'b00 ? "R2 right word" : (f == 2'b01 ? "R4 right word" : (f == 2'b10 ? "R5 right word" : "R6 right word")),
             {24'h0, capr}, {24'h0, expect_word(f, rv)});
         chk("R8 no error on good frame", 48'(nerr), 48'd0);
      end

      // R3: short word padded with zeros, long word truncated
      do_reset(2'b00);
      prime(2'b00);
      send_frame(2'b00, 16, 32'h0000BEEF, 32'h0, 32);
      chk("R3 short delayed word", {24'h0, capl}, {24'h0, 24'hBEEF00});
      nval = 0;
      send_frame(2'b00, 28, 32'h0ABCDEF1, 32'h0ABCDEF1, 32);
      chk("R3 long delayed word truncated", {24'h0, capr}, {24'h0, 24'hABCDEF});
      chk("R7 back-to-back frame delivered", 48'(nval), 48'd1);

      // R8: short right-aligned slot
      do_reset(2'b01);
      prime(2'b01);
      send_frame(2'b01, 24, 32'h1234, 32'h5678, 12);
      chk("R8 error pulse on short slot", 48'(nerr), 48'd1);
      chk("R8 no pair for bad frame", 48'(nval), 48'd0);
      send_frame(2'b01, 24, 32'h4321, 32'h8765, 32);
      chk("R8 recovery pair count", 48'(nval), 48'd1);
      chk("R8 recovery left", {24'h0, capl}, {24'h0, 24'h004321});
      chk("R8 recovery right", {24'h0, capr}, {24'h0, 24'hFF8765});

      // R9: partial word at start discarded, R7 steering after it
      do_reset(2'b11);
      for (int i = 0; i < 10; i++) put_bit(1'b1, 1'b1);
      put_bit(1'b0, 1'b1);
      chk("R9 no pair from partial start", 48'(nval), 48'd0);
      chk("R9 no error from partial start", 48'(nerr), 48'd0);
      send_frame(2'b11, 24, 32'h00C0FFEE, 32'h00123456, 32);
      chk("R9 first full frame count", 48'(nval), 48'd1);
      chk("R7 left steering", {24'h0, capl}, {24'h0, 24'hC0FFEE});
      chk("R7 right steering", {24'h0, capr}, {24'h0, 24'h123456});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule